// File: doc/BRIEF.md
# Combining Write Buffer

This block sits between a write-through data cache and the memory port. Each store the core issues goes into the cache and into this buffer in the same cycle. The buffer keeps the store's word address, a per-byte enable mask and the data. It then sends those entries to memory one at a time over a valid/ready write channel. The core waits only when the buffer has no room for a store.

When a store targets a word that already sits in a queued entry, the buffer folds the new bytes into that entry. It does not open a new one. The entry at the head is the exception: it is being offered to memory and is never modified, so a store to the same word opens a new entry behind it.

On a read miss the cache presents the missed word address. If no queued entry holds that word, the buffer reports completion at once. Otherwise it keeps draining in order and reports completion once every entry for that word has been written to memory. The fill then reads up-to-date memory. Stores are held off while a read lookup is pending.

Top module: `wr_combine_buf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `mem_valid` is 0.
- R2: Accepted stores to distinct words reach memory in arrival order, one per `mem_valid && mem_ready` cycle. Each write carries the store's word address, byte enables (bit i enables data bits 8i+7..8i) and data unchanged.
- R3: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_be` and `mem_data` stay constant.
- R4: A store whose word address matches a queued entry other than the head is merged into that entry, and no new entry is taken. Each enabled byte replaces the stored byte, and the entry's enable mask becomes the OR of the old and new masks.
- R5: A store whose word address matches only the head entry takes a new entry, so memory sees two separate writes to that word.
- R6: `full` is 1 when all DEPTH entries (default 4) are taken. `st_ready` is 0 then for a store to a new word, and 1 for a store that can merge.
- R7: A store with all byte enables 0 is accepted whenever `st_ready` is 1 and changes nothing: it takes no entry and causes no memory write.
- R8: While `rd_valid` is 1, `rd_done` is 1 in the same cycle when no queued entry holds `rd_addr`. Otherwise `rd_done` is 0 until the last entry holding that word has completed its memory handshake, and is 1 from the next cycle on.
- R9: `st_ready` is 0 while `rd_valid` is 1.
- R10: `empty` is 1 exactly when no entry is queued, and `mem_valid` is 0 whenever `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request from the core |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | AW | Store word address |
| st_be | input | DW/8 | Store byte enables |
| st_data | input | DW | Store data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Memory write word address |
| mem_be | output | DW/8 | Memory write byte enables |
| mem_data | output | DW | Memory write data |
| rd_valid | input | 1 | Read-miss lookup pending |
| rd_addr | input | AW | Read-miss word address |
| rd_done | output | 1 | Memory now holds current data for `rd_addr` |
| full | output | 1 | All entries taken |
| empty | output | 1 | No entry taken |

## Verification
Corrupted occupancy or a head pointer that skips an entry shows at the memory port. The drained sequence loses, repeats or reorders writes, and the flags disagree with the number of writes that actually come out. This appears within a few cycles of `mem_ready` rising.

A wrong merge decision shows in the byte mask and data of the drained write, or as an extra or missing write. A lookup that ignores queued entries raises `rd_done` before the matching write has completed its handshake, which is visible in the same cycle the lookup starts.

// File: rtl/wr_combine_buf.sv
module wr_combine_buf #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW/8-1:0] st_be,
  input  logic [DW-1:0]   st_data,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_data,
  input  logic            rd_valid,
  input  logic [AW-1:0]   rd_addr,
  output logic            rd_done,
  output logic            full,
  output logic            empty
);
  localparam int BW = DW / 8;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] ent_vld;
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [BW-1:0]    ent_be   [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    count;

  logic          mrg_hit;
  logic [PW-1:0] mrg_idx;
  logic          rd_match;
  logic          take, push, merge, pop;

  always_comb begin
    mrg_hit = 1'b0;
    mrg_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!mrg_hit && ent_vld[i] && head != PW'(i) && ent_addr[i] == st_addr) begin
        mrg_hit = 1'b1;
        mrg_idx = PW'(i);
      end
    end
  end

  always_comb begin
    rd_match = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (ent_vld[i] && ent_addr[i] == rd_addr) rd_match = 1'b1;
  end

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign st_ready  = !rd_valid && (mrg_hit || !full);
  assign take      = st_valid && st_ready && (|st_be);
  assign push      = take && !mrg_hit;
  assign merge     = take && mrg_hit;
  assign mem_valid = !empty;
  assign pop       = mem_valid && mem_ready;
  assign mem_addr  = ent_addr[head];
  assign mem_be    = ent_be[head];
  assign mem_data  = ent_data[head];
  assign rd_done   = rd_valid && !rd_match;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_addr[i] <= '0;
        ent_be[i]   <= '0;
        ent_data[i] <= '0;
      end
    end else begin
      if (pop) begin
        ent_vld[head] <= 1'b0;
        head          <= nxt(head);
      end
      if (push) begin
        ent_vld[tail]  <= 1'b1;
        ent_addr[tail] <= st_addr;
        ent_be[tail]   <= st_be;
        ent_data[tail] <= st_data;
        tail           <= nxt(tail);
      end
      if (merge) begin
        ent_be[mrg_idx] <= ent_be[mrg_idx] | st_be;
        for (int b = 0; b < BW; b++)
          if (st_be[b]) ent_data[mrg_idx][8*b +: 8] <= st_data[8*b +: 8];
      end
      count <= count + CW'(push) - CW'(pop);
    end
  end

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_data));

  p_full_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && st_valid && st_ready && !mem_ready |=> full);

  p_no_empty_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_be != '0);

  p_idle_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !mem_valid);

  p_done_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_done |=> !rd_valid || rd_done || !$stable(rd_addr));

endmodule

// File: tb/test_wr_combine_buf.sv
module test_wr_combine_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [3:0] st_be = '0;
  logic [DW-1:0] st_data = '0;
  logic mem_valid, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [DW-1:0] mem_data;
  logic rd_valid = 1'b0, rd_done;
  logic [AW-1:0] rd_addr = '0;
  logic full, empty;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [AW-1:0] log_addr [16];
  logic [3:0]    log_be   [16];
  logic [DW-1:0] log_data [16];
  int n_log = 0;

  wr_combine_buf #(.DEPTH(4), .AW(AW), .DW(DW)) i_wr_combine_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_be(mem_be), .mem_data(mem_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done), .full(full), .empty(empty));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    if (mem_valid && mem_ready && n_log < 16) begin
      log_addr[n_log] = mem_addr;
      log_be[n_log]   = mem_be;
      log_data[n_log] = mem_data;
      n_log++;
    end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d, output bit acc);
    st_valid = 1'b1; st_addr = a; st_be = be; st_data = d;
    @(negedge clk); acc = st_ready;
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic drain();
    mem_ready = 1'b1;
    for (int i = 0; i < 40 && !(empty === 1'b1); i++) @(negedge clk);
    @(posedge clk); #1;
    mem_ready = 1'b0;
  endtask

  task automatic chk_log(input int k, input string req, input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
    chk(log_addr[k] == a, req, 64'(log_addr[k]), 64'(a));
    chk(log_be[k] == be, req, 64'(log_be[k]), 64'(be));
    chk(log_data[k] == d, req, 64'(log_data[k]), 64'(d));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(empty === 1'b1, "R1", 64'(empty), 1);
    chk(full === 1'b0, "R1", 64'(full), 0);
    chk(mem_valid === 1'b0, "R1 R10", 64'(mem_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_fifo();
    bit acc;
    n_log = 0;
    store(30'h100, 4'hF, 32'hA0A0_0001, acc); chk(acc, "R2", 64'(acc), 1);
    store(30'h200, 4'h3, 32'hB0B0_0002, acc); chk(acc, "R2", 64'(acc), 1);
    store(30'h300, 4'h8, 32'hC0C0_0003, acc); chk(acc, "R2", 64'(acc), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(mem_valid === 1'b1 && mem_addr == 30'h100 && mem_be == 4'hF && mem_data == 32'hA0A0_0001,
          "R3", 64'(mem_addr), 64'h100);
    end
    chk(empty === 1'b0, "R10", 64'(empty), 0);
    @(posedge clk); #1;
    drain();
    chk(n_log == 3, "R2", 64'(n_log), 3);
    chk_log(0, "R2", 30'h100, 4'hF, 32'hA0A0_0001);
    chk_log(1, "R2", 30'h200, 4'h3, 32'hB0B0_0002);
    chk_log(2, "R2", 30'h300, 4'h8, 32'hC0C0_0003);
    @(negedge clk);
    chk(empty === 1'b1 && mem_valid === 1'b0, "R10", 64'(empty), 1);
    @(posedge clk); #1;
  endtask

  task automatic t_merge();
    bit acc;
    n_log = 0;
    store(30'h010, 4'hF, 32'h0000_0010, acc);
    store(30'h020, 4'h3, 32'h1111_2222, acc);
    store(30'h020, 4'hC, 32'h3333_4444, acc); chk(acc, "R4", 64'(acc), 1);
    store(30'h030, 4'hF, 32'h0000_0030, acc);
    @(negedge clk);
    chk(full === 1'b0, "R4 entry count", 64'(full), 0);
    @(posedge clk); #1;
    store(30'h040, 4'hF, 32'h0000_0040, acc);
    @(negedge clk);
    chk(full === 1'b1, "R6", 64'(full), 1);
    @(posedge clk); #1;
    drain();
    chk(n_log == 4, "R4", 64'(n_log), 4);
    chk_log(1, "R4", 30'h020, 4'hF, 32'h3333_2222);
    chk_log(2, "R4", 30'h030, 4'hF, 32'h0000_0030);
  endtask

  task automatic t_head();
    bit acc;
    n_log = 0;
    store(30'h050, 4'h3, 32'h0000_5555, acc);
    store(30'h050, 4'hC, 32'h6666_0000, acc); chk(acc, "R5", 64'(acc), 1);
    drain();
    chk(n_log == 2, "R5", 64'(n_log), 2);
    chk_log(0, "R5", 30'h050, 4'h3, 32'h0000_5555);
    chk_log(1, "R5", 30'h050, 4'hC, 32'h6666_0000);
  endtask

  task automatic t_full();
    bit acc;
    n_log = 0;
    for (int i = 0; i < 4; i++) store(30'h400 + 30'(i), 4'h6, 32'h0012_3400 + 32'(i), acc);
    @(negedge clk);
    chk(full === 1'b1, "R6", 64'(full), 1);
    @(posedge clk); #1;
    store(30'h4FF, 4'hF, 32'hDEAD_BEEF, acc);
    chk(!acc, "R6 new word stalled", 64'(acc), 0);
    store(30'h402, 4'h1, 32'h0000_00EE, acc);
    chk(acc, "R6 merge while full", 64'(acc), 1);
    drain();
    chk(n_log == 4, "R6", 64'(n_log), 4);
    chk_log(2, "R6", 30'h402, 4'h7, 32'h0012_34EE);
  endtask

  task automatic t_zero();
    bit acc;
    n_log = 0;
    store(30'h777, 4'h0, 32'hFFFF_FFFF, acc);
    chk(acc, "R7", 64'(acc), 1);
    repeat (2) @(negedge clk);
    chk(empty === 1'b1 && mem_valid === 1'b0, "R7", 64'(empty), 1);
    @(posedge clk); #1;
    drain();
    chk(n_log == 0, "R7", 64'(n_log), 0);
  endtask

  task automatic t_read();
    bit acc;
    n_log = 0;
    store(30'h0A0, 4'hF, 32'hAAAA_0000, acc);
    store(30'h0B0, 4'hF, 32'hBBBB_0000, acc);
    store(30'h0C0, 4'hF, 32'hCCCC_0000, acc);
    rd_valid = 1'b1; rd_addr = 30'h0D0;
    @(negedge clk);
    chk(rd_done === 1'b1, "R8 no match", 64'(rd_done), 1);
    @(posedge clk); #1;
    rd_addr = 30'h0B0; mem_ready = 1'b1;
    st_valid = 1'b1; st_addr = 30'h0E0; st_be = 4'hF; st_data = 32'hEEEE_0000;
    @(negedge clk);
    chk(rd_done === 1'b0, "R8 wait", 64'(rd_done), 0);
    chk(st_ready === 1'b0, "R9", 64'(st_ready), 0);
    @(negedge clk);
    chk(rd_done === 1'b0, "R8 wait", 64'(rd_done), 0);
    chk(st_ready === 1'b0, "R9", 64'(st_ready), 0);
    @(negedge clk);
    chk(rd_done === 1'b1, "R8 done", 64'(rd_done), 1);
    chk(n_log == 2, "R8 drained through match", 64'(n_log), 2);
    chk(empty === 1'b0, "R8 later entry kept", 64'(empty), 0);
    @(posedge clk); #1;
    rd_valid = 1'b0; st_valid = 1'b0;
    drain();
    chk(n_log == 3, "R9 store blocked", 64'(n_log), 3);
    chk_log(2, "R8", 30'h0C0, 4'hF, 32'hCCCC_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_fifo();
    t_merge();
    t_head();
    t_full();
    t_zero();
    t_read();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule